// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers fifteen level-sensitive request lines (bits 1 to 15 of `irq_req`; bit 0 is not a source) and picks one active request to hand to a processor as a vector number. Out of reset it works in a fixed order where the lowest-numbered active source wins. After software loads a rank table and switches to programmed mode, the ranks are searched from rank 0 upward, and the first rank whose source is active supplies its own vector.

When the processor acknowledges, the block registers the winning vector. It saves the mask that was in force on an internal nesting stack, then loads the winner's entry from a per-source mask table. That entry normally blocks every source of lower priority. An end-of-interrupt strobe pops the stack and restores the saved mask. Nested interrupts therefore unwind in the correct order. The effective mask is the software enable register ANDed with the current nesting mask, and software can read it back.

Register map (6-bit address, 16-bit data, reads combinational):

| Address | Contents |
|---|---|
| 0x00 | [0] programmed mode, [7:4] count of ranks searched |
| 0x01 | enable |
| 0x02 | effective mask (read only) |
| 0x03 | [0] sticky overflow, [7:4] nesting depth; any write clears overflow |
| 0x10+r, r = 0..14 | rank r: [3:0] source, [15:8] vector |
| 0x20+s, s = 1..15 | mask-table entry for source s |

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset: `irq_vec` = 0xFF (the reserved unused code), `irq_out` = 0, enable = 0xFFFF, effective mask = 0xFFFE, status = 0, control = 0 (fixed-order mode).
- R2: `irq_out` is 1 exactly when some source in bits 1..15 is both requested and set in the effective mask; bit 0 never raises it.
- R3: In fixed-order mode an acknowledge reports the lowest-numbered active unmasked source as its vector (sources 3, 5 and 11 together give 3).
- R4: An acknowledge with no active unmasked source reports 0xFF, and leaves the mask and depth unchanged.
- R5: In programmed mode only ranks 0..count-1 are searched, lowest rank first, and the vector of the first rank whose source is active and unmasked is reported. Ranks at or above count are ignored.
- R6: An acknowledge with a winner increments the depth and replaces the nesting mask with the winner's mask-table entry. Reset entries are (1<<s)-1, which blocks source s and every higher number.
- R7: End-of-interrupt restores the mask saved by the matching acknowledge, in last-in first-out order, and decrements the depth.
- R8: The stack holds 15 levels. An acknowledge at depth 15 changes neither vector, mask nor depth, and it sets the sticky overflow bit. Only a write to address 0x03 clears that bit.
- R9: End-of-interrupt at depth 0 changes neither mask nor depth.
- R10: `irq_vec` changes only on an acknowledge, whatever the requests do in between.
- R11: Writing a mask-table entry while nested changes neither the current mask nor any mask already saved on the stack.
- R12: When acknowledge and end-of-interrupt are high in the same cycle, the acknowledge is performed and the end-of-interrupt is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | 16 | Level requests, bits 1..15 used |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| irq_out | output | 1 | Any active unmasked request |
| irq_vec | output | 8 | Registered vector of the last acknowledge |
| irq_ack | input | 1 | Acknowledge strobe |
| irq_eoi | input | 1 | End-of-interrupt strobe |

## Verification
Fixed-order selection is tried with three simultaneous requests, so that a lowest-index rule can be told apart from any other order. Programmed mode is then loaded with a table that reverses that order, which separates a rank-driven search from an index-driven one. A request that sits only at a rank beyond the search count shows whether the count bound is honoured. Two-level nesting, followed by a mask-table rewrite while nested, distinguishes a real saved-mask stack from one that recomputes masks out of the table. Filling the stack to fifteen and acknowledging once more checks the overflow boundary, and a same-cycle acknowledge and end-of-interrupt checks which strobe wins.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int NSRC = 15;          // request lines 1..NSRC
    localparam int LW   = NSRC + 1;    // line vector width, bit 0 unused
    localparam int IDW  = 4;           // source id width
    localparam int VW   = 8;           // vector width
    localparam int AW   = 6;           // register address width
    localparam int DW   = 16;          // register data width

    typedef struct packed {
        logic [IDW-1:0] src;
        logic [VW-1:0]  vec;
    } rank_t;

    typedef struct packed {
        logic                  prog;
        logic [IDW-1:0]        cnt;
        logic [LW-1:0]         en;
        logic                  ovf;
        logic [VW-1:0]         vec;
        logic [LW-1:0]         nmask;
        rank_t [NSRC-1:0]      rank;
        logic [NSRC:1][LW-1:0] mtab;
    } ctl_t;
endpackage

// File: rtl/pic_select.sv
module pic_select
    import pic_pkg::*;
(
    input  logic                  prog,
    input  logic [IDW-1:0]        cnt,
    input  logic [LW-1:0]         live,
    input  rank_t [NSRC-1:0]      rank,
    output logic                  hit,
    output logic [IDW-1:0]        src,
    output logic [VW-1:0]         vec
);
    // Scan from the far end so that the lowest index found is kept last.
    always_comb begin
        hit = 1'b0;
        src = '0;
        vec = '0;
        if (!prog) begin
            for (int s = NSRC; s >= 1; s--) begin
                if (live[s]) begin
                    hit = 1'b1;
                    src = IDW'(s);
                    vec = VW'(s);
                end
            end
        end else begin
            for (int r = NSRC - 1; r >= 0; r--) begin
                if (r < int'(cnt) && rank[r].src != '0 && live[rank[r].src]) begin
                    hit = 1'b1;
                    src = rank[r].src;
                    vec = rank[r].vec;
                end
            end
        end
    end
endmodule

// File: rtl/pic_nest_stack.sv
module pic_nest_stack #(
    parameter int DEPTH = 15,
    parameter int W     = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] depth,
    output logic          full,
    output logic          empty
);
    logic [DEPTH-1:0][W-1:0] mem_d, mem_q;
    logic [CW-1:0]           ptr_d, ptr_q;
    logic [CW-1:0]           top_idx;

    assign full    = (ptr_q == CW'(DEPTH));
    assign empty   = (ptr_q == '0);
    assign depth   = ptr_q;
    assign top_idx = empty ? '0 : ptr_q - 1'b1;
    assign dout    = mem_q[top_idx];

    always_comb begin
        mem_d = mem_q;
        ptr_d = ptr_q;
        if (push && !full) begin
            mem_d[ptr_q] = din;
            ptr_d        = ptr_q + 1'b1;
        end else if (pop && !empty) begin
            ptr_d = ptr_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
            ptr_q <= '0;
        end else begin
            mem_q <= mem_d;
            ptr_q <= ptr_d;
        end
    end

    // R8: the controller never pushes onto a full stack
    assert_push_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R9: the controller never pops an empty stack
    assert_pop_guard_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter int          DEPTH      = 15,
    parameter logic [7:0]  UNUSED_VEC = 8'hFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [15:0]   irq_req,
    input  logic          reg_we,
    input  logic [5:0]    reg_addr,
    input  logic [15:0]   reg_wdata,
    output logic [15:0]   reg_rdata,
    output logic          irq_out,
    output logic [7:0]    irq_vec,
    input  logic          irq_ack,
    input  logic          irq_eoi
);
    localparam int CW = $clog2(DEPTH + 1);

    ctl_t q, d;

    logic [LW-1:0]  eff, live;
    logic           sel_hit;
    logic [IDW-1:0] sel_src;
    logic [VW-1:0]  sel_vec;
    logic           push, pop, full, empty;
    logic [LW-1:0]  saved;
    logic [CW-1:0]  depth;

    function automatic ctl_t reset_value();
        ctl_t r;
        r       = '0;
        r.en    = '1;
        r.nmask = '1;
        r.vec   = UNUSED_VEC;
        for (int s = 1; s <= NSRC; s++) begin
            r.mtab[s] = (LW'(1) << s) - LW'(1);
        end
        return r;
    endfunction

    assign eff     = q.en & q.nmask & ~LW'(1);
    assign live    = irq_req & eff;
    assign irq_out = |live;
    assign irq_vec = q.vec;

    pic_select u_sel (
        .prog (q.prog),
        .cnt  (q.cnt),
        .live (live),
        .rank (q.rank),
        .hit  (sel_hit),
        .src  (sel_src),
        .vec  (sel_vec)
    );

    assign push = irq_ack && sel_hit && !full;
    assign pop  = irq_eoi && !irq_ack && !empty;

    pic_nest_stack #(.DEPTH(DEPTH), .W(LW)) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .din   (q.nmask),
        .dout  (saved),
        .depth (depth),
        .full  (full),
        .empty (empty)
    );

    always_comb begin
        d = q;
        if (reg_we) begin
            if (reg_addr == 6'h00) begin
                d.prog = reg_wdata[0];
                d.cnt  = reg_wdata[7:4];
            end else if (reg_addr == 6'h01) begin
                d.en = reg_wdata;
            end else if (reg_addr == 6'h03) begin
                d.ovf = 1'b0;
            end else if (reg_addr[5:4] == 2'b01 && int'(reg_addr[3:0]) < NSRC) begin
                d.rank[reg_addr[3:0]].src = reg_wdata[3:0];
                d.rank[reg_addr[3:0]].vec = reg_wdata[15:8];
            end else if (reg_addr[5:4] == 2'b10 && reg_addr[3:0] != '0) begin
                d.mtab[reg_addr[3:0]] = reg_wdata;
            end
        end
        if (irq_ack) begin
            if (full) begin
                d.ovf = 1'b1;
            end else if (sel_hit) begin
                d.vec   = sel_vec;
                d.nmask = q.mtab[sel_src];
            end else begin
                d.vec = UNUSED_VEC;
            end
        end else if (pop) begin
            d.nmask = saved;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= reset_value();
        else        q <= d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr[5:4])
            2'b00: begin
                case (reg_addr[3:0])
                    4'h0:    reg_rdata = {8'h00, q.cnt, 3'b000, q.prog};
                    4'h1:    reg_rdata = q.en;
                    4'h2:    reg_rdata = eff;
                    4'h3:    reg_rdata = {8'h00, 4'(depth), 3'b000, q.ovf};
                    default: reg_rdata = '0;
                endcase
            end
            2'b01: if (int'(reg_addr[3:0]) < NSRC)
                       reg_rdata = {q.rank[reg_addr[3:0]].vec, 4'h0, q.rank[reg_addr[3:0]].src};
            2'b10: if (reg_addr[3:0] != '0) reg_rdata = q.mtab[reg_addr[3:0]];
            default: reg_rdata = '0;
        endcase
    end

    // R10: the vector register moves only on an acknowledge
    assert_vec_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_ack |=> $stable(irq_vec));
    // R4: nothing pending at acknowledge gives the unused code
    assert_no_winner_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !irq_out && !full) |=> (irq_vec == UNUSED_VEC));
    // R6: an accepted acknowledge deepens the stack by one
    assert_push_depth_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && sel_hit && !full) |=> (depth == $past(depth) + 1'b1));
    // R8: overflow is sticky until its register is written
    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ovf && !(reg_we && reg_addr == 6'h03)) |=> q.ovf);
    // R9: end-of-interrupt on an empty stack leaves the mask alone
    assert_eoi_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_eoi && !irq_ack && empty) |=> ($stable(q.nmask) && depth == '0));
endmodule

// File: tb/tb_prio_irq_ctrl.sv
`timescale 1ns/100ps
module tb_prio_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_req = '0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq_out;
    logic [7:0]  irq_vec;
    logic        irq_ack = 1'b0;
    logic        irq_eoi = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] exp_vec[$];
    string      exp_tag[$];

    prio_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_out(irq_out), .irq_vec(irq_vec), .irq_ack(irq_ack), .irq_eoi(irq_eoi)
    );

    always #2.5 clk = ~clk;

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: every acknowledge produces one vector to compare
    initial begin
        forever begin
            @(posedge clk);
            if (irq_ack && rst_n) begin
                @(negedge clk);
                if (exp_vec.size() == 0) begin
                    check(16'(irq_vec), 16'hDEAD, "unexpected acknowledge");
                end else begin
                    check(16'(irq_vec), 16'(exp_vec[0]), exp_tag[0]);
                    void'(exp_vec.pop_front());
                    void'(exp_tag.pop_front());
                end
            end
        end
    end

    task automatic wr(input logic [5:0] a, input logic [15:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [5:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(reg_rdata, exp, tag);
    endtask

    // Driver: queue the expected vector, then strobe acknowledge
    task automatic ack(input logic [7:0] e, input string tag, input logic with_eoi = 1'b0);
        @(negedge clk);
        exp_vec.push_back(e);
        exp_tag.push_back(tag);
        irq_ack = 1'b1;
        irq_eoi = with_eoi;
        @(negedge clk);
        irq_ack = 1'b0;
        irq_eoi = 1'b0;
    endtask

    task automatic eoi();
        @(negedge clk);
        irq_eoi = 1'b1;
        @(negedge clk);
        irq_eoi = 1'b0;
    endtask

    task automatic req(input logic [15:0] v);
        @(negedge clk);
        irq_req = v;
        #1;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        #1;
        check(16'(irq_vec), 16'h00FF, "R1 vector");
        check(16'(irq_out), 16'h0, "R1 irq_out");
        rd_chk(6'h01, 16'hFFFF, "R1 enable");
        rd_chk(6'h02, 16'hFFFE, "R1 eff mask");
        rd_chk(6'h03, 16'h0000, "R1 status");
        rd_chk(6'h00, 16'h0000, "R1 control");

        // R2 output gating
        req(16'h0001);
        check(16'(irq_out), 16'h0, "R2 bit0 ignored");
        req(16'h0828);
        check(16'(irq_out), 16'h1, "R2 request seen");
        wr(6'h01, 16'h0000);
        #1 check(16'(irq_out), 16'h0, "R2 disabled");
        wr(6'h01, 16'hFFFF);

        // R3 fixed order, R6 mask load
        ack(8'd3, "R3 lowest of 3,5,11");
        rd_chk(6'h02, 16'h0006, "R6 mask of source 3");
        check(16'(irq_out), 16'h0, "R6 lower sources blocked");
        rd_chk(6'h03, 16'h0010, "R6 depth 1");
        eoi();
        rd_chk(6'h02, 16'hFFFE, "R7 restore");

        // R7 two-level nesting
        req(16'h0020);
        ack(8'd5, "R3 source 5 alone");
        rd_chk(6'h02, 16'h001E, "R6 mask of source 5");
        req(16'h0024);
        check(16'(irq_out), 16'h1, "R2 higher source passes");
        ack(8'd2, "R3 nested source 2");
        rd_chk(6'h03, 16'h0020, "R6 depth 2");
        rd_chk(6'h02, 16'h0002, "R6 mask of source 2");
        eoi();
        rd_chk(6'h02, 16'h001E, "R7 first pop");
        eoi();
        rd_chk(6'h02, 16'hFFFE, "R7 second pop");

        // R9 spurious end-of-interrupt
        eoi();
        rd_chk(6'h02, 16'hFFFE, "R9 mask kept");
        rd_chk(6'h03, 16'h0000, "R9 depth kept");

        // R4 nothing pending
        req(16'h0000);
        ack(8'hFF, "R4 unused code");
        rd_chk(6'h03, 16'h0000, "R4 no push");

        // R10 vector held between acknowledges
        req(16'h0008);
        ack(8'd3, "R10 setup");
        req(16'h0002);
        repeat (3) @(negedge clk);
        check(16'(irq_vec), 16'h0003, "R10 held");
        eoi();

        // R5 programmed order
        wr(6'h10, 16'h4505);
        wr(6'h11, 16'h4303);
        wr(6'h12, 16'h4B0B);
        wr(6'h25, 16'h0000);
        wr(6'h23, 16'h0020);
        wr(6'h00, 16'h0021);
        req(16'h0828);
        ack(8'h45, "R5 rank 0 first");
        check(16'(irq_out), 16'h0, "R5 source 3 masked");
        eoi();
        req(16'h0808);
        ack(8'h43, "R5 rank 1 after release");
        eoi();
        req(16'h0800);
        check(16'(irq_out), 16'h1, "R5 line active");
        ack(8'hFF, "R5 rank beyond count");
        wr(6'h00, 16'h0031);
        ack(8'h4B, "R5 count widened");
        eoi();

        // R11 table rewrite while nested
        req(16'h0008);
        ack(8'h43, "R11 outer");
        rd_chk(6'h02, 16'h0020, "R11 outer mask");
        wr(6'h23, 16'hFFFF);
        rd_chk(6'h02, 16'h0020, "R11 current mask untouched");
        req(16'h0028);
        ack(8'h45, "R11 inner");
        rd_chk(6'h02, 16'h0000, "R11 inner mask");
        eoi();
        rd_chk(6'h02, 16'h0020, "R11 saved mask untouched");
        eoi();
        rd_chk(6'h02, 16'hFFFE, "R11 unwound");

        // R8 overflow
        wr(6'h00, 16'h0000);
        wr(6'h21, 16'hFFFF);
        req(16'h0002);
        for (int i = 0; i < 15; i++) ack(8'd1, "R8 fill");
        rd_chk(6'h03, 16'h00F0, "R8 full depth");
        req(16'h0004);
        ack(8'd1, "R8 ignored acknowledge keeps vector");
        rd_chk(6'h03, 16'h00F1, "R8 overflow set");
        repeat (2) @(negedge clk);
        rd_chk(6'h03, 16'h00F1, "R8 overflow sticky");
        wr(6'h03, 16'h0000);
        rd_chk(6'h03, 16'h00F0, "R8 overflow cleared");
        for (int i = 0; i < 15; i++) eoi();
        rd_chk(6'h02, 16'hFFFE, "R8 unwound");

        // R12 simultaneous strobes
        req(16'h0002);
        ack(8'd1, "R12 ack wins", 1'b1);
        rd_chk(6'h03, 16'h0010, "R12 eoi dropped");
        eoi();
        rd_chk(6'h03, 16'h0000, "R12 later eoi");

        repeat (3) @(negedge clk);
        check(16'(exp_vec.size()), 16'h0, "scoreboard drained");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule